// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit with Overflow Detection

This block is a purely combinational 32-bit integer arithmetic logic unit. Two operands and a 4-bit mode select go in. A 32-bit result comes out, along with three flags: carry, overflow and zero. It supports signed and unsigned addition and subtraction, four bitwise logic functions, and signed and unsigned set-less-than comparison. A processor datapath uses it as its execute stage, with the mode driven by an instruction decoder outside the block.

A single carry-lookahead adder serves all arithmetic and compare modes. For subtraction and compare, the second operand is inverted and the adder carry-in is forced to one, so the adder computes A plus not-B plus one. Overflow is the carry into the most significant bit XOR the carry out of it. Only the signed add and signed subtract modes report it. The signed compare corrects the sign of the difference with that overflow term. The unsigned compare uses the inverted carry-out, which is the borrow.

Top module: `int_alu`

## Requirements
- R1: Mode 0 (signed add) and mode 1 (unsigned add) produce `result` = A + B modulo 2^32. `carry_out` is the carry out of bit 31.
- R2: Mode 2 (signed subtract) and mode 3 (unsigned subtract) produce `result` = A - B modulo 2^32. `carry_out` is the carry out of A + ~B + 1, so it is 1 exactly when A >= B as unsigned values.
- R3: `ovf` is 1 in mode 0 exactly when A and B have the same sign bit and the result's sign bit differs from it. `ovf` is 1 in mode 2 exactly when A and B differ in sign bit and the result's sign bit differs from A's. In every other mode `ovf` is 0.
- R4: Mode 4 gives A AND B, mode 5 gives A OR B, mode 6 gives A XOR B and mode 7 gives NOT(A OR B). `carry_out` is 0 in all four.
- R5: Mode 10 (signed set-less-than) gives `result` = 1 when A < B as two's-complement values, else 0. This holds even when A - B overflows. Bits 31..1 are always 0, and `carry_out` is 0.
- R6: Mode 11 (unsigned set-less-than) gives `result` = 1 when A < B as unsigned values, else 0. Bits 31..1 are always 0, and `carry_out` is 0.
- R7: `zero` is 1 exactly when all 32 bits of `result` are 0, in every mode.
- R8: Mode codes 8, 9, 12, 13, 14 and 15 give `result` = 0 with `carry_out` = 0 and `ovf` = 0, and therefore `zero` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand (A) |
| opnd_b | input | 32 | Second operand (B) |
| mode | input | 4 | Operation select, encoded as in R1 to R8 |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Adder carry-out for the add and subtract modes, else 0 |
| ovf | output | 1 | Signed overflow for the signed add and signed subtract modes, else 0 |
| zero | output | 1 | All result bits are zero |

## Verification
All 16 mode codes are applied to a fixed set of boundary operands and to random pairs. The boundary operands are 0, 1, all-ones, the most positive value and the most negative value.

The boundary pairs drive the carry chain end to end and force signed overflow in both directions. They separate the carry-into-MSB XOR carry-out overflow rule from a plain sign check, and they separate the corrected signed compare from a raw sign test. Pairs that are equal, and pairs that differ only in the top bit, tell signed ordering apart from unsigned ordering and exercise the zero flag.

Random pairs cover the group boundaries inside the lookahead adder. Running the undefined codes against the same operands shows that they stay silent whatever the inputs are.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        MODE_ADD  = 4'd0,
        MODE_ADDU = 4'd1,
        MODE_SUB  = 4'd2,
        MODE_SUBU = 4'd3,
        MODE_AND  = 4'd4,
        MODE_OR   = 4'd5,
        MODE_XOR  = 4'd6,
        MODE_NOR  = 4'd7,
        MODE_SLT  = 4'd10,
        MODE_SLTU = 4'd11
    } alu_mode_e;

    typedef enum logic [1:0] {
        LOGIC_AND = 2'd0,
        LOGIC_OR  = 2'd1,
        LOGIC_XOR = 2'd2,
        LOGIC_NOR = 2'd3
    } logic_fn_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_SUM   = 3'd1,
        SRC_LOGIC = 3'd2,
        SRC_SLT   = 3'd3,
        SRC_SLTU  = 3'd4
    } res_src_e;

    typedef struct packed {
        logic      invert_b;   // adder sees ~B and carry-in 1
        logic      keep_carry; // carry flag is meaningful
        logic      keep_ovf;   // overflow flag is meaningful
        res_src_e  src;
        logic_fn_e lfn;
    } ctrl_t;

    typedef struct packed {
        logic c_into_msb;
        logic c_out;
    } carry_t;

    function automatic ctrl_t decode_mode(input logic [3:0] m);
        ctrl_t c;
        c = '{invert_b: 1'b0, keep_carry: 1'b0, keep_ovf: 1'b0,
              src: SRC_NONE, lfn: LOGIC_AND};
        case (m)
            MODE_ADD:  begin c.src = SRC_SUM; c.keep_carry = 1'b1; c.keep_ovf = 1'b1; end
            MODE_ADDU: begin c.src = SRC_SUM; c.keep_carry = 1'b1; end
            MODE_SUB:  begin c.src = SRC_SUM; c.keep_carry = 1'b1; c.keep_ovf = 1'b1;
                             c.invert_b = 1'b1; end
            MODE_SUBU: begin c.src = SRC_SUM; c.keep_carry = 1'b1; c.invert_b = 1'b1; end
            MODE_AND:  begin c.src = SRC_LOGIC; c.lfn = LOGIC_AND; end
            MODE_OR:   begin c.src = SRC_LOGIC; c.lfn = LOGIC_OR;  end
            MODE_XOR:  begin c.src = SRC_LOGIC; c.lfn = LOGIC_XOR; end
            MODE_NOR:  begin c.src = SRC_LOGIC; c.lfn = LOGIC_NOR; end
            MODE_SLT:  begin c.src = SRC_SLT;  c.invert_b = 1'b1; end
            MODE_SLTU: begin c.src = SRC_SLTU; c.invert_b = 1'b1; end
            default:   c.src = SRC_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_cla_adder.sv
module alu_cla_adder #(
    parameter int WIDTH = 32,
    parameter int GRP   = 4
) (
    input  logic [WIDTH-1:0]     a,
    input  logic [WIDTH-1:0]     b,
    input  logic                 cin,
    output logic [WIDTH-1:0]     sum,
    output int_alu_pkg::carry_t  carries
);
    localparam int NGRP = WIDTH / GRP;

    logic [NGRP:0]    gc;      // carries at group boundaries
    logic [WIDTH-1:0] bit_cin; // carry into each bit

    assign gc[0] = cin;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        logic [GRP-1:0] gen_b, prp_b;
        logic [GRP:0]   lc;
        logic           grp_g, grp_p;

        assign gen_b = a[k*GRP +: GRP] & b[k*GRP +: GRP];
        assign prp_b = a[k*GRP +: GRP] ^ b[k*GRP +: GRP];
        assign lc[0] = gc[k];

        for (genvar j = 0; j < GRP; j++) begin : g_bit
            assign lc[j+1] = gen_b[j] | (prp_b[j] & lc[j]);
        end

        always_comb begin
            grp_g = 1'b0;
            grp_p = 1'b1;
            for (int j = 0; j < GRP; j++) begin
                grp_g = gen_b[j] | (prp_b[j] & grp_g);
                grp_p = grp_p & prp_b[j];
            end
        end

        // group lookahead: boundary carry does not wait for the inner ripple
        assign gc[k+1] = grp_g | (grp_p & gc[k]);
        assign sum[k*GRP +: GRP]     = prp_b ^ lc[GRP-1:0];
        assign bit_cin[k*GRP +: GRP] = lc[GRP-1:0];
    end

    assign carries.c_into_msb = bit_cin[WIDTH-1];
    assign carries.c_out      = gc[NGRP];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]       a,
    input  logic [WIDTH-1:0]       b,
    input  int_alu_pkg::logic_fn_e fn,
    output logic [WIDTH-1:0]       y
);
    import int_alu_pkg::*;

    logic [WIDTH-1:0] y_or;
    assign y_or = a | b;

    always_comb begin
        unique case (fn)
            LOGIC_AND: y = a & b;
            LOGIC_OR:  y = y_or;
            LOGIC_XOR: y = a ^ b;
            LOGIC_NOR: y = ~y_or;
            default:   y = '0;
        endcase
    end
endmodule

// File: rtl/alu_out_stage.sv
module alu_out_stage #(
    parameter int WIDTH = 32
) (
    input  int_alu_pkg::ctrl_t    ctrl,
    input  logic [WIDTH-1:0]      sum,
    input  int_alu_pkg::carry_t   carries,
    input  logic [WIDTH-1:0]      logic_y,
    output logic [WIDTH-1:0]      result,
    output logic                  carry_out,
    output logic                  ovf,
    output logic                  zero
);
    import int_alu_pkg::*;

    logic raw_ovf, lt_signed, lt_unsigned;

    assign raw_ovf     = carries.c_into_msb ^ carries.c_out;
    assign lt_signed   = sum[WIDTH-1] ^ raw_ovf;
    assign lt_unsigned = ~carries.c_out;

    always_comb begin
        result = '0;
        unique case (ctrl.src)
            SRC_SUM:   result = sum;
            SRC_LOGIC: result = logic_y;
            SRC_SLT:   result[0] = lt_signed;
            SRC_SLTU:  result[0] = lt_unsigned;
            default:   result = '0;
        endcase
    end

    assign carry_out = ctrl.keep_carry & carries.c_out;
    assign ovf       = ctrl.keep_ovf & raw_ovf;
    assign zero      = ~|result;
endmodule

// File: rtl/int_alu.sv
module int_alu (
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [3:0]  mode,
    output logic [31:0] result,
    output logic        carry_out,
    output logic        ovf,
    output logic        zero
);
    import int_alu_pkg::*;

    localparam int WIDTH = 32;
    localparam int GRP   = 4;

    ctrl_t            ctrl;
    logic [WIDTH-1:0] b_eff, sum, logic_y;
    carry_t           carries;

    assign ctrl  = decode_mode(mode);
    assign b_eff = ctrl.invert_b ? ~opnd_b : opnd_b;

    alu_cla_adder #(.WIDTH(WIDTH), .GRP(GRP)) u_add (
        .a(opnd_a), .b(b_eff), .cin(ctrl.invert_b),
        .sum(sum), .carries(carries)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a(opnd_a), .b(opnd_b), .fn(ctrl.lfn), .y(logic_y)
    );

    alu_out_stage #(.WIDTH(WIDTH)) u_out (
        .ctrl(ctrl), .sum(sum), .carries(carries), .logic_y(logic_y),
        .result(result), .carry_out(carry_out), .ovf(ovf), .zero(zero)
    );
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk (
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [3:0]  mode,
    input logic [31:0] result,
    input logic        carry_out,
    input logic        ovf,
    input logic        zero
);
    logic is_logic, is_cmp, is_unused;

    assign is_logic  = (mode >= 4'd4) && (mode <= 4'd7);
    assign is_cmp    = (mode == 4'd10) || (mode == 4'd11);
    assign is_unused = (mode == 4'd8) || (mode == 4'd9) || (mode >= 4'd12);

    always_comb begin
        // R3: overflow of a signed add needs equal operand signs
        if (mode == 4'd0 && ovf)
            p_add_ovf_signs_r3: assert (opnd_a[31] == opnd_b[31] && result[31] != opnd_a[31]);
        // R3: overflow of a signed subtract needs differing operand signs
        if (mode == 4'd2 && ovf)
            p_sub_ovf_signs_r3: assert (opnd_a[31] != opnd_b[31] && result[31] != opnd_a[31]);
        // R3: no overflow outside the signed arithmetic modes
        if (mode != 4'd0 && mode != 4'd2)
            p_no_overflow_r3: assert (!ovf);
        // R4: logic modes never carry
        if (is_logic)
            p_logic_no_carry_r4: assert (!carry_out);
        // R5 / R6: compare results are a single bit
        if (is_cmp)
            p_cmp_one_bit_r5: assert (result[31:1] == 31'd0 && !carry_out);
        // R8: undefined codes are silent
        if (is_unused)
            p_unused_quiet_r8: assert (result == 32'd0 && !carry_out && !ovf && zero);
        // R7: zero flag cannot coexist with a set bit
        if (zero)
            p_zero_flag_r7: assert (result == 32'd0);
    end
endmodule

bind int_alu int_alu_chk chk_i (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .mode(mode), .result(result),
    .carry_out(carry_out), .ovf(ovf), .zero(zero)
);

// File: tb/int_alu_tb.sv
module int_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b;
    logic [3:0]  m;
    logic [31:0] result;
    logic        carry_out, ovf, zero;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    int_alu dut_i (
        .opnd_a(a), .opnd_b(b), .mode(m),
        .result(result), .carry_out(carry_out), .ovf(ovf), .zero(zero)
    );

    function automatic string req_of(input logic [3:0] md);
        case (md)
            4'd0, 4'd1:             return "R1";
            4'd2, 4'd3:             return "R2";
            4'd4, 4'd5, 4'd6, 4'd7: return "R4";
            4'd10:                  return "R5";
            4'd11:                  return "R6";
            default:                return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s mode=%0d a=%h b=%h actual=%h expected=%h",
                     req, what, m, a, b, act, exp);
        end
    endtask

    // behavioural reference, applied after the inputs settle
    task automatic apply(input logic [31:0] ta, input logic [31:0] tb,
                         input logic [3:0] tm);
        logic [32:0] wide;
        logic [31:0] e_res;
        logic        e_c, e_v;
        @(negedge clk);
        a = ta; b = tb; m = tm;
        e_res = 32'd0; e_c = 1'b0; e_v = 1'b0;
        case (tm)
            4'd0, 4'd1: begin
                wide  = {1'b0, ta} + {1'b0, tb};
                e_res = wide[31:0];
                e_c   = wide[32];
                if (tm == 4'd0) e_v = (ta[31] == tb[31]) && (e_res[31] != ta[31]);
            end
            4'd2, 4'd3: begin
                e_res = ta - tb;
                e_c   = (ta >= tb);
                if (tm == 4'd2) e_v = (ta[31] != tb[31]) && (e_res[31] != ta[31]);
            end
            4'd4:  e_res = ta & tb;
            4'd5:  e_res = ta | tb;
            4'd6:  e_res = ta ^ tb;
            4'd7:  e_res = ~(ta | tb);
            4'd10: e_res = ($signed(ta) < $signed(tb)) ? 32'd1 : 32'd0;
            4'd11: e_res = (ta < tb) ? 32'd1 : 32'd0;
            default: e_res = 32'd0;
        endcase
        @(posedge clk);
        #1;
        check(req_of(tm), "result", result, e_res);
        check(req_of(tm), "carry_out", {31'd0, carry_out}, {31'd0, e_c});
        check("R3", "ovf", {31'd0, ovf}, {31'd0, e_v});
        check("R7", "zero", {31'd0, zero}, {31'd0, (e_res == 32'd0)});
    endtask

    logic [31:0] corner [8];

    initial begin
        a = '0; b = '0; m = '0;
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h8000_0000; corner[5] = 32'h0000_000F;
        corner[6] = 32'h0000_0010; corner[7] = 32'h8000_0001;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        // idle state: zero operands in add mode (R1, R7)
        check("R1", "idle result", result, 32'd0);
        check("R7", "idle zero", {31'd0, zero}, 32'd1);

        // named corner cases
        apply(32'h7FFF_FFFF, 32'h0000_0001, 4'd0);  // R3 positive overflow
        apply(32'h8000_0000, 32'hFFFF_FFFF, 4'd0);  // R3 negative overflow
        apply(32'h7FFF_FFFF, 32'h0000_0001, 4'd1);  // R3 none for unsigned
        apply(32'hFFFF_FFFF, 32'h0000_0001, 4'd1);  // R1 carry, R7 zero
        apply(32'h8000_0000, 32'h0000_0001, 4'd2);  // R3 subtract overflow
        apply(32'h0000_0005, 32'h0000_0005, 4'd3);  // R2 carry=1 on equal
        apply(32'h8000_0000, 32'h0000_0001, 4'd10); // R5 overflowing compare
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd10); // R5
        apply(32'h8000_0000, 32'h0000_0001, 4'd11); // R6 unsigned differs
        apply(32'hA5A5_0F0F, 32'h5A5A_F0F0, 4'd7);  // R4 NOR to zero
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd12); // R8 quiet

        // every mode against every corner pair
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int md = 0; md < 16; md++)
                    apply(corner[i], corner[j], 4'(md));

        // random pairs, including equal and top-bit-only differences
        for (int r = 0; r < 400; r++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = (r % 7 == 0) ? ra : ((r % 7 == 1) ? (ra ^ 32'h8000_0000) : $urandom());
            apply(ra, rb, 4'(r % 16));
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule